// File: doc/BRIEF.md
# Power Mode Controller

This block holds the 32-bit power control register of a small processor subsystem and decides which low-power state the system should enter. When the core signals wait-for-interrupt, the block reads the sleep-deep qualifier, the stored mode code and a one-way lock bit. It then issues a one-cycle, one-hot request on one of four lines: sleep, deep-sleep, power-down or deep power-down. The clock-gating and power-switch sequencers downstream act on that request.

Software programs the mode code and sets the lock through a plain write port. It reads two sticky status flags through the read port and clears them by writing a one to them. One flag records entry to any of the three lighter states and the other records entry to deep power-down. The block has two reset domains. Power-on reset clears everything. System reset clears the mode code, the light-sleep flag and the request state, but it keeps the lock and the deep power-down flag, which sit in the always-on domain. After the block issues a request it ignores further wait-for-interrupt events until the wake input returns it to the awake state.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After power-on reset, the read data is all zeros and no request line is high.
- R2: Bits 2:0 store and read back any written value from 0 to 7. Bits 7:4, 10:9 and 31:12 always read 0, whatever is written to them.
- R3: A wait-for-interrupt that the block accepts while sleep-deep is low requests sleep (request bit 0), whatever the mode code.
- R4: A wait-for-interrupt accepted with sleep-deep high requests deep-sleep (bit 1) for code 1, power-down (bit 2) for code 2 and deep power-down (bit 3) for code 3 when unlocked. Codes 0 and 4 to 7 request sleep (bit 0).
- R5: The request appears in the cycle after the clock edge that accepts the wait-for-interrupt. It lasts one cycle and has at most one bit high.
- R6: Writing 1 to bit 3 sets the lock. Writing 0 and system reset leave it set. Only power-on reset clears it.
- R7: While the lock is set, a request that would be deep power-down becomes sleep (bit 0). Bit 8 is then set and bit 11 is left unchanged.
- R8: Bit 8 is set on entry to sleep, deep-sleep or power-down. Writing 1 to bit 8 clears it, and writing 0 leaves it unchanged.
- R9: Bit 11 is set on entry to deep power-down. Writing 1 to bit 11 clears it, and writing 0 leaves it unchanged.
- R10: When a write clears a flag in the same cycle that an entry sets it, the flag ends up set.
- R11: System reset clears bits 2:0 and bit 8 and returns the block to the awake state. It keeps bits 3 and 11. While either reset is active, the block ignores writes and wait-for-interrupt events.
- R12: After a request, the block ignores wait-for-interrupt until wake is seen. Wake changes no register bit.
- R13: A write takes effect at the edge that samples it. A wait-for-interrupt accepted at that same edge is decided with the mode code and lock as they stood before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears all state |
| sys_rst_n | input | 1 | System reset, synchronous, active low; spares the always-on bits |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register contents |
| wfi_evt | input | 1 | Wait-for-interrupt event from the core |
| sleepdeep | input | 1 | Deep qualifier sampled with the event |
| wake | input | 1 | Wake indication; returns the block to the awake state |
| pm_req | output | 4 | One-hot request: bit 0 sleep, 1 deep-sleep, 2 power-down, 3 deep power-down |

## Verification
The bench targets the lock. A design that decodes code 3 without the lock would issue deep power-down while locked, and a lock bit placed in the system domain would be cleared by system reset. It drives a flag clear and a flag set in the same cycle, and a write and a wait-for-interrupt in the same cycle. A design with the wrong priority would lose the flag. A design that decides from the newly written mode code would request the wrong state. It also repeats wait-for-interrupt while the block is parked and sends wake alongside it. A design without the parked state would issue a second request, and a design that lets wake touch the register would change the readback.

// File: rtl/pmc_pkg.sv
// Package: shared constants, field positions and types of the power mode
// controller. Assumes the register is at least 12 bits wide.
package pmc_pkg;

    localparam int MODE_LSB   = 0;
    localparam int MODE_W     = 3;
    localparam int LOCK_POS   = 3;
    localparam int SFLAG_POS  = 8;
    localparam int DFLAG_POS  = 11;
    localparam int TGT_N      = 4;
    localparam int MIN_DATA_W = 12;

    // Codes of the stored power-mode field
    typedef enum logic [MODE_W-1:0] {
        PM_RUN    = 3'd0,
        PM_DSLEEP = 3'd1,
        PM_PDOWN  = 3'd2,
        PM_DPD    = 3'd3
    } pm_code_e;

    // Request targets; value equals the request bit index
    typedef enum logic [1:0] {
        TGT_SLEEP  = 2'd0,
        TGT_DSLEEP = 2'd1,
        TGT_PDOWN  = 2'd2,
        TGT_DPD    = 2'd3
    } tgt_e;

    // Request sequencer state
    typedef enum logic {
        ST_AWAKE  = 1'b0,
        ST_PARKED = 1'b1
    } seq_state_e;

    // True for bit positions that hold a register field
    function automatic logic is_live(input int pos);
        return (pos >= MODE_LSB && pos < MODE_LSB + MODE_W) ||
               (pos == LOCK_POS) || (pos == SFLAG_POS) || (pos == DFLAG_POS);
    endfunction

endpackage

// File: rtl/pmc_decode.sv
// Module: pmc_decode
// Purely combinational choice of the low-power target from the sleep-deep
// qualifier, the stored mode code and the lock. Assumes the caller decides
// whether the event is accepted at all.
module pmc_decode
    import pmc_pkg::*;
(
    input  logic              sleepdeep,
    input  logic [MODE_W-1:0] mode,
    input  logic              lock,
    output tgt_e              tgt
);

    // Map qualifier and mode code to a target; the lock vetoes deep power-down
    always_comb begin
        tgt = TGT_SLEEP;
        if (sleepdeep) begin
            case (pm_code_e'(mode))
                PM_DSLEEP: tgt = TGT_DSLEEP;
                PM_PDOWN:  tgt = TGT_PDOWN;
                PM_DPD:    tgt = lock ? TGT_SLEEP : TGT_DPD;
                default:   tgt = TGT_SLEEP;
            endcase
        end
    end

endmodule

// File: rtl/pmc_req_seq.sv
// Module: pmc_req_seq
// Accepts a wait-for-interrupt while awake, emits a registered one-hot
// request pulse, and parks until wake. Assumes rst_n is the AND of both
// synchronous resets.
module pmc_req_seq
    import pmc_pkg::*;
#(
    parameter int N = TGT_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wfi,
    input  logic         wake,
    input  tgt_e         tgt,
    output logic         accept,
    output logic         set_light,
    output logic         set_dpd,
    output logic [N-1:0] req
);

    seq_state_e   state;
    logic [N-1:0] req_d;

    // An event counts only while awake and out of reset
    always_comb accept = rst_n && (state == ST_AWAKE) && wfi;

    // Flag set strobes for the register file, valid on the accepting edge
    always_comb begin
        set_dpd   = accept && (tgt == TGT_DPD);
        set_light = accept && (tgt != TGT_DPD);
    end

    // One-hot expansion of the target, one line per request bit
    for (genvar i = 0; i < N; i++) begin : g_onehot
        assign req_d[i] = accept && (tgt == tgt_e'(i));
    end

    // Awake/parked tracking: park on acceptance, leave on wake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_AWAKE;
        end else if (state == ST_AWAKE) begin
            if (wfi) state <= ST_PARKED;
        end else if (wake) begin
            state <= ST_AWAKE;
        end
    end

    // Request register: a single-cycle pulse after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) req <= '0;
        else        req <= req_d;
    end

endmodule

// File: rtl/pmc_regfile.sv
// Module: pmc_regfile
// Storage of the control register in two reset domains. System-domain
// fields are the mode code and the light-sleep flag; always-on fields are the
// lock and the deep power-down flag. Assumes DATA_W >= MIN_DATA_W.
module pmc_regfile
    import pmc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_mode,
    input  logic              wr_lock,
    input  logic              wr_clr_s,
    input  logic              wr_clr_d,
    input  logic              set_light,
    input  logic              set_dpd,
    output logic [MODE_W-1:0] mode,
    output logic              lock,
    output logic [DATA_W-1:0] rdata
);

    logic sflag;
    logic dflag;

    // System domain: mode code and light flag; set beats clear
    always_ff @(posedge clk) begin
        if (!por_n || !sys_rst_n) begin
            mode  <= '0;
            sflag <= 1'b0;
        end else begin
            if (wr_en) mode <= wr_mode;
            if (set_light)              sflag <= 1'b1;
            else if (wr_en && wr_clr_s) sflag <= 1'b0;
        end
    end

    // Always-on domain: lock and deep flag, cleared by power-on reset only
    always_ff @(posedge clk) begin
        if (!por_n) begin
            lock  <= 1'b0;
            dflag <= 1'b0;
        end else if (sys_rst_n) begin
            if (wr_en && wr_lock) lock <= 1'b1;
            if (set_dpd)                dflag <= 1'b1;
            else if (wr_en && wr_clr_d) dflag <= 1'b0;
        end
    end

    // Readback assembly: live fields at their positions, zero elsewhere
    for (genvar b = 0; b < DATA_W; b++) begin : g_rd
        if (b >= MODE_LSB && b < MODE_LSB + MODE_W) begin : g_mode
            assign rdata[b] = mode[b-MODE_LSB];
        end else if (b == LOCK_POS) begin : g_lock
            assign rdata[b] = lock;
        end else if (b == SFLAG_POS) begin : g_sflag
            assign rdata[b] = sflag;
        end else if (b == DFLAG_POS) begin : g_dflag
            assign rdata[b] = dflag;
        end else begin : g_rsvd
            assign rdata[b] = 1'b0;
        end
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Module: pwr_mode_ctrl
// Power mode controller top: register file, target decode and request
// sequencer. Assumes both resets are synchronous and active low, and
// DATA_W >= 12.
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              wfi_evt,
    input  logic              sleepdeep,
    input  logic              wake,
    output logic [TGT_N-1:0]  pm_req
);

    logic              rst_n;
    logic [MODE_W-1:0] mode;
    logic              lock;
    tgt_e              tgt;
    logic              accept;
    logic              set_light;
    logic              set_dpd;
    logic [DATA_W-1:0] rsvd_wbits;
    logic              wdata_unused;

    // Combined reset for the parts that both resets clear
    always_comb rst_n = por_n && sys_rst_n;

    // Reserved write bits are collected only to mark them as deliberately unused
    for (genvar b = 0; b < DATA_W; b++) begin : g_rsvd_w
        if (is_live(b)) begin : g_live
            assign rsvd_wbits[b] = 1'b0;
        end else begin : g_dead
            assign rsvd_wbits[b] = reg_wdata[b];
        end
    end
    assign wdata_unused = ^{rsvd_wbits, accept};

    pmc_regfile #(
        .DATA_W (DATA_W)
    ) regs_i (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .wr_en     (reg_wr),
        .wr_mode   (reg_wdata[MODE_LSB +: MODE_W]),
        .wr_lock   (reg_wdata[LOCK_POS]),
        .wr_clr_s  (reg_wdata[SFLAG_POS]),
        .wr_clr_d  (reg_wdata[DFLAG_POS]),
        .set_light (set_light),
        .set_dpd   (set_dpd),
        .mode      (mode),
        .lock      (lock),
        .rdata     (reg_rdata)
    );

    pmc_decode dec_i (
        .sleepdeep (sleepdeep),
        .mode      (mode),
        .lock      (lock),
        .tgt       (tgt)
    );

    pmc_req_seq #(
        .N (TGT_N)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wfi       (wfi_evt),
        .wake      (wake),
        .tgt       (tgt),
        .accept    (accept),
        .set_light (set_light),
        .set_dpd   (set_dpd),
        .req       (pm_req)
    );

endmodule

// File: rtl/pmc_chk.sv
// Module: pmc_chk
// Port-level properties of the power mode controller, bound to the top.
// Assumes por_n is low from time zero.
module pmc_chk
    import pmc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              por_n,
    input logic              sys_rst_n,
    input logic [DATA_W-1:0] rdata,
    input logic [TGT_N-1:0]  req
);

    logic [DATA_W-1:0] rsvd_view;

    // Reserved positions of the readback, gathered for the zero check
    for (genvar b = 0; b < DATA_W; b++) begin : g_view
        if (is_live(b)) begin : g_live
            assign rsvd_view[b] = 1'b0;
        end else begin : g_dead
            assign rsvd_view[b] = rdata[b];
        end
    end

    // R5
    req_onehot_chk: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(req));

    // R5
    req_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        (req != '0) |=> (req == '0));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        rsvd_view == '0);

    // R6
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        rdata[LOCK_POS] |=> rdata[LOCK_POS]);

    // R7
    lock_veto_chk: assert property (@(posedge clk) disable iff (!por_n)
        rdata[LOCK_POS] |=> !req[TGT_DPD]);

    // R8
    light_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
        (req[TGT_SLEEP] || req[TGT_DSLEEP] || req[TGT_PDOWN]) |-> rdata[SFLAG_POS]);

    // R9
    deep_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
        req[TGT_DPD] |-> rdata[DFLAG_POS]);

    // R11
    sysrst_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |=> (rdata[MODE_LSB +: MODE_W] == '0) && !rdata[SFLAG_POS] && (req == '0));

    // R11
    sysrst_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst_n && rdata[DFLAG_POS]) |=> rdata[DFLAG_POS]);

endmodule

bind pwr_mode_ctrl pmc_chk #(
    .DATA_W (DATA_W)
) chk_i (
    .clk       (clk),
    .por_n     (por_n),
    .sys_rst_n (sys_rst_n),
    .rdata     (reg_rdata),
    .req       (pm_req)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: directed and random stimulus, a behavioural reference model that
// is compared on every clock, and directed checks per requirement.
module pwr_mode_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wfi_evt = 1'b0;
    logic        sleepdeep = 1'b0;
    logic        wake = 1'b0;
    logic [3:0]  pm_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int live_cycles = 0;

    // Reference model state
    logic [2:0] m_mode;
    bit         m_lock, m_sf, m_df, m_park;
    logic [3:0] m_req;

    always #4 clk = ~clk;

    pwr_mode_ctrl dut_i (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .wfi_evt   (wfi_evt),
        .sleepdeep (sleepdeep),
        .wake      (wake),
        .pm_req    (pm_req)
    );

    // Reference model, advanced on each rising edge
    always @(posedge clk) begin
        int pick;
        pick = -1;
        if (!por_n) begin
            m_mode = 3'd0; m_lock = 0; m_sf = 0; m_df = 0; m_park = 0; m_req = 4'd0;
            live_cycles = 0;
        end else if (!sys_rst_n) begin
            m_mode = 3'd0; m_sf = 0; m_park = 0; m_req = 4'd0;
            live_cycles = live_cycles + 1;
        end else begin
            live_cycles = live_cycles + 1;
            if (!m_park && wfi_evt) begin
                if (!sleepdeep)                   pick = 0;
                else if (m_mode == 3'd1)          pick = 1;
                else if (m_mode == 3'd2)          pick = 2;
                else if (m_mode == 3'd3 && !m_lock) pick = 3;
                else                              pick = 0;
            end else if (m_park && wake) begin
                m_park = 0;
            end
            if (reg_wr) begin
                m_mode = reg_wdata[2:0];
                if (reg_wdata[3])  m_lock = 1;
                if (reg_wdata[8])  m_sf = 0;
                if (reg_wdata[11]) m_df = 0;
            end
            m_req = 4'd0;
            if (pick >= 0) begin
                m_req[pick] = 1'b1;
                m_park = 1;
                if (pick == 3) m_df = 1;
                else           m_sf = 1;
            end
        end
    end

    // Every-clock comparison with the model (R2, R4, R5, R8, R9, R11, R12)
    always @(negedge clk) begin
        logic [31:0] exp_rd;
        if (live_cycles > 0 || !por_n) begin
            exp_rd = '0;
            exp_rd[2:0] = m_mode;
            exp_rd[3]   = m_lock;
            exp_rd[8]   = m_sf;
            exp_rd[11]  = m_df;
            checks++;
            if (reg_rdata !== exp_rd || pm_req !== m_req) begin
                errors++;
                $display("FAIL model R2/R4/R5/R8/R9/R11/R12 t=%0t rdata act=%h exp=%h req act=%b exp=%b",
                         $time, reg_rdata, exp_rd, pm_req, m_req);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus, then wait to the following falling edge
    task automatic cyc(input bit wr, input logic [31:0] wd, input bit wf, input bit sd, input bit wk);
        reg_wr = wr; reg_wdata = wd; wfi_evt = wf; sleepdeep = sd; wake = wk;
        @(negedge clk);
        reg_wr = 0; wfi_evt = 0; wake = 0;
    endtask

    task automatic idle();
        cyc(0, 32'h0, 0, 0, 0);
    endtask

    task automatic do_por();
        por_n = 0;
        repeat (3) idle();
        por_n = 1;
    endtask

    task automatic do_sysrst();
        sys_rst_n = 0;
        repeat (2) idle();
        sys_rst_n = 1;
    endtask

    initial begin
        @(negedge clk);
        do_por();
        // R1 reset state
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 req", {28'h0, pm_req}, 32'h0);

        // R2 field readback, reserved bits read zero
        cyc(1, 32'h5, 0, 0, 0);
        chk("R2 mode=5", reg_rdata, 32'h5);
        cyc(1, 32'hFFFF_FFF7, 0, 0, 0);
        chk("R2 reserved zero", reg_rdata, 32'h7);

        // R3 shallow request despite mode 1
        cyc(1, 32'h1, 0, 0, 0);
        cyc(0, 0, 1, 0, 0);
        chk("R3 req sleep", {28'h0, pm_req}, 32'h1);
        chk("R8 flag set", reg_rdata, 32'h101);
        idle();
        chk("R5 pulse ends", {28'h0, pm_req}, 32'h0);
        cyc(0, 0, 0, 0, 1);

        // R4 deep decode of each code
        cyc(0, 0, 1, 1, 0);
        chk("R4 code1", {28'h0, pm_req}, 32'h2);
        cyc(0, 0, 0, 0, 1);
        cyc(1, 32'h2, 0, 0, 0);
        cyc(0, 0, 1, 1, 0);
        chk("R4 code2", {28'h0, pm_req}, 32'h4);
        cyc(0, 0, 0, 0, 1);
        cyc(1, 32'h0, 0, 0, 0);
        cyc(0, 0, 1, 1, 0);
        chk("R4 code0", {28'h0, pm_req}, 32'h1);
        cyc(0, 0, 0, 0, 1);
        cyc(1, 32'h6, 0, 0, 0);
        cyc(0, 0, 1, 1, 0);
        chk("R4 code6", {28'h0, pm_req}, 32'h1);
        cyc(0, 0, 0, 0, 1);

        // R8 write 0 keeps, write 1 clears
        cyc(1, 32'h0, 0, 0, 0);
        chk("R8 write0 keeps", reg_rdata, 32'h100);
        cyc(1, 32'h100, 0, 0, 0);
        chk("R8 write1 clears", reg_rdata, 32'h0);

        // R9 deep power-down flag
        cyc(1, 32'h3, 0, 0, 0);
        cyc(0, 0, 1, 1, 0);
        chk("R4 code3", {28'h0, pm_req}, 32'h8);
        chk("R9 flag set", reg_rdata, 32'h803);
        cyc(0, 0, 0, 0, 1);
        cyc(1, 32'h3, 0, 0, 0);
        chk("R9 write0 keeps", reg_rdata, 32'h803);
        cyc(1, 32'h803, 0, 0, 0);
        chk("R9 write1 clears", reg_rdata, 32'h3);

        // R12 parked until wake; wake leaves register alone
        cyc(0, 0, 1, 1, 0);
        chk("R12 first req", {28'h0, pm_req}, 32'h8);
        cyc(0, 0, 1, 1, 0);
        chk("R12 parked ignores", {28'h0, pm_req}, 32'h0);
        cyc(0, 0, 1, 1, 1);
        chk("R12 wake with event", {28'h0, pm_req}, 32'h0);
        chk("R12 wake no reg change", reg_rdata, 32'h803);

        // R10 set beats same-cycle clear
        cyc(1, 32'h1, 0, 0, 0);
        cyc(1, 32'h101, 1, 1, 0);
        chk("R10 req", {28'h0, pm_req}, 32'h2);
        chk("R10 flag kept", reg_rdata, 32'h901);
        cyc(0, 0, 0, 0, 1);

        // R13 decision uses pre-write mode code
        cyc(1, 32'h3, 1, 1, 0);
        chk("R13 old mode", {28'h0, pm_req}, 32'h2);
        chk("R13 new mode stored", reg_rdata, 32'h903);
        cyc(0, 0, 0, 0, 1);

        // R6 lock set and sticky against write 0
        cyc(1, 32'hB, 0, 0, 0);
        chk("R6 lock set", reg_rdata, 32'h90B);
        cyc(1, 32'h903, 0, 0, 0);
        chk("R6 write0 keeps lock", reg_rdata, 32'h00B);

        // R7 locked deep request becomes sleep
        cyc(0, 0, 1, 1, 0);
        chk("R7 req sleep", {28'h0, pm_req}, 32'h1);
        chk("R7 flags", reg_rdata, 32'h10B);
        cyc(0, 0, 0, 0, 1);

        // R11 system reset keeps lock, clears rest, unparks
        cyc(0, 0, 1, 0, 0);
        do_sysrst();
        chk("R11 sysrst", reg_rdata, 32'h8);
        cyc(0, 0, 1, 0, 0);
        chk("R11 unparked", {28'h0, pm_req}, 32'h1);

        // R6 only power-on reset clears the lock
        do_por();
        chk("R6 por clears", reg_rdata, 32'h0);

        // R13 same-cycle lock write does not veto; R11 deep flag survives
        cyc(1, 32'h3, 0, 0, 0);
        cyc(1, 32'hB, 1, 1, 0);
        chk("R13 old lock", {28'h0, pm_req}, 32'h8);
        chk("R13 lock now set", reg_rdata, 32'h80B);
        do_sysrst();
        chk("R11 deep flag kept", reg_rdata, 32'h808);

        // Random phase, model compared every clock
        do_por();
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] wd;
            wd = $urandom();
            wd[3] = ($urandom_range(0, 39) == 0);
            sys_rst_n = ($urandom_range(0, 39) != 0);
            por_n     = ($urandom_range(0, 299) != 0);
            cyc($urandom_range(0, 3) == 0, wd, $urandom_range(0, 2) == 0,
                $urandom_range(0, 1) == 1, $urandom_range(0, 4) == 0);
        end
        por_n = 1; sys_rst_n = 1;
        idle();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule